// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Arbitration

The block is a 2048-word by 8-bit memory that two independent agents reach through a left and a right port. Each port has an active-low chip enable, a read/write select, an active-low output enable, an 11-bit address and separate 8-bit write and read buses. A three-state data pin is modelled by a drive flag. When the drive flag is low, the read bus is forced to zero.

An arbiter watches for the case where both enabled ports point at the same word. The port whose enable and address were already steady keeps the access. The port that arrived later sees its active-low busy output fall, and any write it attempts is dropped. If both ports arrive in the same clock cycle, the left port wins. Busy is re-evaluated every cycle from the present inputs and the previous cycle's port state.

With the mode input tied high, the block acts as a subordinate device. The busy outputs stay high, and a per-port active-low inhibit input blocks that port's writes.

Top module: `dpram_busy_arb`

## Requirements
- R1: A port with chip enable high (deselected) holds drive low and read data at 0, and a write attempted through it leaves memory unchanged.
- R2: A port with chip enable low and read/write select 0 writes its write data to the addressed word at the clock edge, unless that port is blocked.
- R3: A port with chip enable low, read/write select 1 and output enable low raises drive and presents the addressed word combinationally. With output enable high, drive is low and read data is 0.
- R4: A busy output is low only when both chip enables are low and both addresses are equal. Otherwise both busy outputs are high in the same cycle.
- R5: On a same-address match, the port whose enable/address pair changed in this cycle receives busy. The port whose pair held since an earlier cycle proceeds.
- R6: If both ports' pairs change in the same cycle and match, the right port receives busy.
- R7: The two busy outputs are never low together.
- R8: In master mode (mode input 0), a port whose busy output is low writes nothing. The winner's write proceeds.
- R9: In subordinate mode (mode input 1), both busy outputs are held high. An inhibit input at 0 blocks its port's writes, and an inhibit input at 1 allows them.
- R10: In master mode the inhibit inputs have no effect.
- R11: Busy stays with the same port while the match persists. It releases in the cycle in which the addresses differ or either chip enable goes high.
- R12: In subordinate mode, when both ports write the same word in the same cycle, the left port's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of arbitration state |
| slave_mode | input | 1 | 0 = master (busy outputs driven), 1 = subordinate (inhibit inputs used) |
| l_cs_n | input | 1 | Left chip enable, active low |
| l_rw | input | 1 | Left read (1) / write (0) select |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 11 | Left address |
| l_wdata | input | 8 | Left write data |
| l_inhibit_n | input | 1 | Left write inhibit, active low, subordinate mode only |
| l_rdata | output | 8 | Left read data, 0 when not driving |
| l_drive | output | 1 | Left data bus drive flag |
| l_busy_n | output | 1 | Left busy, active low |
| r_cs_n | input | 1 | Right chip enable, active low |
| r_rw | input | 1 | Right read (1) / write (0) select |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 11 | Right address |
| r_wdata | input | 8 | Right write data |
| r_inhibit_n | input | 1 | Right write inhibit, active low, subordinate mode only |
| r_rdata | output | 8 | Right read data, 0 when not driving |
| r_drive | output | 1 | Right data bus drive flag |
| r_busy_n | output | 1 | Right busy, active low |

## Verification
The arbitration registers hold the previous enable, the previous address and the last loser. A wrong value in any of them shows up at the busy outputs in the first cycle of a persisting match: the wrong port is flagged, or neither port is. A wrongly gated write is silent until the word is read back, so every collision scenario is followed by reads of the contested word from both ports. The reference model also compares drive, read data and busy on every clock, so an error in read decoding appears in the same cycle it occurs.

// File: rtl/dpram_busy_arb.sv
module dpram_busy_arb #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_mode,
  input  logic          l_cs_n,
  input  logic          l_rw,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          l_inhibit_n,
  output logic [DW-1:0] l_rdata,
  output logic          l_drive,
  output logic          l_busy_n,
  input  logic          r_cs_n,
  input  logic          r_rw,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  input  logic          r_inhibit_n,
  output logic [DW-1:0] r_rdata,
  output logic          r_drive,
  output logic          r_busy_n
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          l_en_q, r_en_q, l_lost_q;
  logic [AW-1:0] l_addr_q, r_addr_q;

  wire l_en  = !l_cs_n;
  wire r_en  = !r_cs_n;
  wire l_new = l_en && (!l_en_q || l_addr != l_addr_q);
  wire r_new = r_en && (!r_en_q || r_addr != r_addr_q);
  wire match = l_en && r_en && (l_addr == r_addr);

  wire l_lose = match && (l_new ? !r_new : (!r_new && l_lost_q));
  wire r_lose = match && !l_lose;

  wire l_block = slave_mode ? !l_inhibit_n : l_lose;
  wire r_block = slave_mode ? !r_inhibit_n : r_lose;

  wire l_wr_en = l_en && !l_rw && !l_block;
  wire r_wr_en = r_en && !r_rw && !r_block;

  assign l_busy_n = slave_mode || !l_lose;
  assign r_busy_n = slave_mode || !r_lose;

  assign l_drive = l_en && l_rw && !l_oe_n;
  assign r_drive = r_en && r_rw && !r_oe_n;
  assign l_rdata = l_drive ? mem[l_addr] : '0;
  assign r_rdata = r_drive ? mem[r_addr] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_en_q   <= 1'b0;
      r_en_q   <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
      l_lost_q <= 1'b0;
    end else begin
      l_en_q   <= l_en;
      r_en_q   <= r_en;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
      l_lost_q <= l_lose;
    end
  end

  always_ff @(posedge clk) begin
    if (r_wr_en) mem[r_addr] <= r_wdata;
    if (l_wr_en) mem[l_addr] <= l_wdata;
  end
endmodule

module dpram_busy_arb_chk #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slave_mode,
  input logic          l_cs_n,
  input logic          l_oe_n,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_drive,
  input logic          l_busy_n,
  input logic          l_inhibit_n,
  input logic          l_wr_en,
  input logic          r_cs_n,
  input logic          r_oe_n,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata,
  input logic          r_drive,
  input logic          r_busy_n,
  input logic          r_inhibit_n,
  input logic          r_wr_en
);
  assert_busy_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!l_busy_n && !r_busy_n));

  assert_busy_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs_n || r_cs_n || l_addr != r_addr) |-> (l_busy_n && r_busy_n));

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    l_cs_n |-> (!l_drive && l_rdata == '0 && !l_wr_en));

  assert_oe_high_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (r_oe_n || r_cs_n) |-> (!r_drive && r_rdata == '0));

  assert_loser_no_write_l_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !l_busy_n) |-> !l_wr_en);

  assert_loser_no_write_r_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!slave_mode && !r_busy_n) |-> !r_wr_en);

  assert_slave_busy_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    slave_mode |-> (l_busy_n && r_busy_n));

  assert_slave_inhibit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (slave_mode && (!l_inhibit_n || !r_inhibit_n)) |->
      ((l_inhibit_n || !l_wr_en) && (r_inhibit_n || !r_wr_en)));
endmodule

bind dpram_busy_arb dpram_busy_arb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .slave_mode(slave_mode),
  .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_rdata(l_rdata),
  .l_drive(l_drive), .l_busy_n(l_busy_n), .l_inhibit_n(l_inhibit_n), .l_wr_en(l_wr_en),
  .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_rdata(r_rdata),
  .r_drive(r_drive), .r_busy_n(r_busy_n), .r_inhibit_n(r_inhibit_n), .r_wr_en(r_wr_en)
);

// File: tb/test_dpram_busy_arb.sv
module test_dpram_busy_arb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slave_mode = 1'b0;
  logic l_cs_n = 1'b1, l_rw = 1'b1, l_oe_n = 1'b1, l_inhibit_n = 1'b1;
  logic r_cs_n = 1'b1, r_rw = 1'b1, r_oe_n = 1'b1, r_inhibit_n = 1'b1;
  logic [10:0] l_addr = '0, r_addr = '0;
  logic [7:0]  l_wdata = '0, r_wdata = '0;
  logic [7:0]  l_rdata, r_rdata;
  logic        l_drive, r_drive, l_busy_n, r_busy_n;

  always #10 clk = ~clk;

  dpram_busy_arb i_dpram_busy_arb (.*);

  int vectors = 0, miscompares = 0, cycles = 0;
  string cur_req = "R1";

  int  m_mem [2048];
  bit  m_valid [2048];
  int  l_age = 0, r_age = 0;
  bit  l_prev_en = 0, r_prev_en = 0;
  int  l_prev_addr = 0, r_prev_addr = 0;
  int  l_age_now, r_age_now;
  bit  m_l_lose, m_r_lose;

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic predict();
    bit match;
    l_age_now = (!l_cs_n && l_prev_en && l_addr == l_prev_addr) ? l_age + 1 : 0;
    r_age_now = (!r_cs_n && r_prev_en && r_addr == r_prev_addr) ? r_age + 1 : 0;
    match = !l_cs_n && !r_cs_n && (l_addr == r_addr);
    m_l_lose = match && (l_age_now < r_age_now);
    m_r_lose = match && !(l_age_now < r_age_now);
  endtask

  task automatic compare();
    bit ld, rd;
    predict();
    ld = !l_cs_n && l_rw && !l_oe_n;
    rd = !r_cs_n && r_rw && !r_oe_n;
    chk("l_drive", l_drive, ld);
    chk("r_drive", r_drive, rd);
    chk("l_busy_n", l_busy_n, slave_mode ? 1 : !m_l_lose);
    chk("r_busy_n", r_busy_n, slave_mode ? 1 : !m_r_lose);
    if (!ld) chk("l_rdata", l_rdata, 0);
    else if (m_valid[l_addr]) chk("l_rdata", l_rdata, m_mem[l_addr]);
    if (!rd) chk("r_rdata", r_rdata, 0);
    else if (m_valid[r_addr]) chk("r_rdata", r_rdata, m_mem[r_addr]);
  endtask

  task automatic commit();
    bit lb, rb;
    lb = slave_mode ? !l_inhibit_n : m_l_lose;
    rb = slave_mode ? !r_inhibit_n : m_r_lose;
    if (!r_cs_n && !r_rw && !rb) begin m_mem[r_addr] = r_wdata; m_valid[r_addr] = 1; end
    if (!l_cs_n && !l_rw && !lb) begin m_mem[l_addr] = l_wdata; m_valid[l_addr] = 1; end
    l_age = l_age_now; r_age = r_age_now;
    l_prev_en = !l_cs_n; r_prev_en = !r_cs_n;
    l_prev_addr = l_addr; r_prev_addr = r_addr;
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      #2 compare();
      @(posedge clk);
      #1 commit();
      @(negedge clk);
    end
  endtask

  task automatic setl(bit cs_n, bit rw, bit oe_n, int a, int d);
    l_cs_n = cs_n; l_rw = rw; l_oe_n = oe_n; l_addr = a[10:0]; l_wdata = d[7:0];
  endtask

  task automatic setr(bit cs_n, bit rw, bit oe_n, int a, int d);
    r_cs_n = cs_n; r_rw = rw; r_oe_n = oe_n; r_addr = a[10:0]; r_wdata = d[7:0];
  endtask

  task automatic idle();
    setl(1, 1, 1, 0, 0); setr(1, 1, 1, 0, 0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1"; idle(); tick(2);

    cur_req = "R2";
    setl(0, 0, 1, 5, 'hA5); setr(0, 0, 1, 6, 'h3C); tick();
    idle(); tick();

    cur_req = "R3";
    setl(0, 1, 0, 5, 0); setr(0, 1, 1, 6, 0); tick();
    setr(0, 1, 0, 6, 0); tick();

    cur_req = "R1";
    setl(1, 0, 1, 5, 'hFF); setr(0, 1, 0, 5, 0); tick(2);

    cur_req = "R4";
    setl(0, 1, 0, 5, 0); setr(0, 1, 0, 6, 0); tick(2);
    idle(); tick();

    cur_req = "R5";
    setl(0, 0, 1, 10, 'h11); tick();
    idle(); tick();
    setl(0, 1, 0, 10, 0); tick();
    setr(0, 1, 0, 10, 0); tick();
    cur_req = "R8";
    setr(0, 0, 1, 10, 'h99); tick(2);
    setr(1, 1, 1, 0, 0); tick();
    idle(); tick();
    cur_req = "R5";
    setr(0, 1, 0, 10, 0); tick();
    cur_req = "R8";
    setl(0, 0, 1, 10, 'h44); tick(2);

    cur_req = "R11";
    setl(0, 0, 1, 11, 'h22); tick();
    setl(0, 1, 0, 10, 0); tick(3);
    setr(1, 1, 1, 0, 0); tick();
    idle(); tick();

    cur_req = "R6";
    setl(0, 0, 1, 12, 'h55); setr(0, 0, 1, 12, 'h77); tick(3);
    setl(0, 1, 0, 12, 0); setr(0, 1, 0, 12, 0); tick(2);
    idle(); tick();

    cur_req = "R10";
    l_inhibit_n = 0; r_inhibit_n = 0;
    setl(0, 0, 1, 13, 'h13); setr(0, 0, 1, 14, 'h14); tick();
    setl(0, 1, 0, 13, 0); setr(0, 1, 0, 14, 0); tick();
    idle(); tick();

    cur_req = "R9";
    slave_mode = 1; l_inhibit_n = 0; r_inhibit_n = 1;
    setl(0, 0, 1, 13, 'hAA); setr(0, 0, 1, 15, 'hBB); tick();
    setl(0, 1, 0, 13, 0); setr(0, 1, 0, 15, 0); tick();
    setl(0, 1, 0, 15, 0); setr(0, 1, 0, 15, 0); tick();
    l_inhibit_n = 1; r_inhibit_n = 0;
    setl(0, 0, 1, 16, 'h61); setr(0, 0, 1, 17, 'h62); tick();
    r_inhibit_n = 1;
    setr(0, 0, 1, 17, 'h63); tick();
    setl(0, 1, 0, 17, 0); setr(0, 1, 0, 16, 0); tick();

    cur_req = "R12";
    setl(0, 0, 1, 20, 'h01); setr(0, 0, 1, 20, 'h02); tick(2);
    setl(0, 1, 0, 20, 0); setr(0, 1, 0, 20, 0); tick();

    cur_req = "R7";
    slave_mode = 0;
    setl(0, 1, 0, 20, 0); setr(0, 1, 0, 20, 0); tick(2);
    idle(); tick();
    finish_run();
  end
endmodule